// File: doc/BRIEF.md
# Serial Tuning-Word Loader with Clock-Domain Hand-off

This block receives a frequency tuning word over a three-wire serial link (serial clock, data line, frame sync) and delivers it to a synthesizer clock domain as a 48-bit additive frequency term. The serial clock may run at any rate and phase relative to the synthesizer clock. The word is one to five bytes long. Its length is set by a configuration input that is read when each frame starts.

A completed word is left-aligned so that its first bit lands on bit 47 of the output term. It is then written into a holding register in the serial domain. A toggle flag crosses to the synthesizer domain through two synchronizer flops. There an edge detector copies the holding register into the output register and returns an acknowledge toggle. The holding register does not change until that acknowledge comes back. A word that completes while a hand-off is still open is kept in a one-entry stage, and the newest staged word wins. A gate input can force the term to zero without losing the stored word.

Top module: `serial_tune_loader`

## Requirements
- R1: After reset, `tune_word` is zero and `tune_upd` is low.
- R2: A frame starts at a rising `sclk` edge that samples `ssync` high. The `sdata` bit sampled at that same edge is the word's most significant bit. One further bit is sampled on each later rising edge.
- R3: `cfg_bytes` is read at frame start and gives the word length in bytes. A value of 0 acts as 1, and values 6 and 7 act as 5. The internal bit count never exceeds 8 times the latched length.
- R4: A word of N bytes appears in `tune_word[47:48-8N]` in arrival order. All lower bits are zero.
- R5: When no hand-off is open, a completed word reaches `tune_word` within a few `clk` cycles. `tune_upd` is high for exactly the `clk` cycle in which the new value is first shown.
- R6: While a hand-off is unacknowledged, the serial-domain holding register stays unchanged.
- R7: A new `ssync` in the middle of a frame abandons the partial word. A partial word never reaches `tune_word`.
- R8: A word that completes during an open hand-off is staged, and a later word replaces the staged one. The staged word is delivered after the acknowledge returns, so the last word sent is always the final value shown.
- R9: `term_en` low forces `tune_word` to zero. Raising it again shows the stored word without a new transfer.
- R10: With `term_en` steady, the stored output word changes only in a cycle that raises `tune_upd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synthesizer-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sclk | input | 1 | Serial clock, asynchronous to `clk` |
| sdata | input | 1 | Serial data, MSB first |
| ssync | input | 1 | Frame-start marker, high for one `sclk` cycle |
| cfg_bytes | input | 3 | Word length in bytes (clamped to 1..5) |
| term_en | input | 1 | Enables the term; low forces zero |
| tune_word | output | 48 | Left-aligned frequency term |
| tune_upd | output | 1 | One-cycle pulse when a new word is shown |

## Verification
Directed frames of each length 1 to 5 confirm left-alignment and zero fill. Out-of-range length codes show that clamping works. A frame cut short by a fresh sync shows that partial words are discarded. A burst of three one-byte frames at a very fast serial clock forces the staging path; the bench checks that only words from the burst appear, that the first update is the first word, and that the last update is the final word. Random words, lengths and serial clock periods then cover arbitrary phase relations between the two clocks.

// File: rtl/stl_pkg.sv
`timescale 1ns/1ps
package stl_pkg;
  // Clamp a requested byte count into 1..max_bytes.
  function automatic int clamp_len(input int req, input int max_bytes);
    if (req < 1) return 1;
    if (req > max_bytes) return max_bytes;
    return req;
  endfunction
endpackage

// File: rtl/stl_shifter.sv
`timescale 1ns/1ps
module stl_shifter #(
  parameter int MAX_BYTES = 5,
  parameter int BYTE_W    = 8,
  localparam int WORD_W   = MAX_BYTES * BYTE_W,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int CNT_W    = $clog2(WORD_W + 1)
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              sdata,
  input  logic              ssync,
  input  logic [LEN_W-1:0]  cfg_bytes,
  input  logic              ack_tgl,
  output logic [WORD_W-1:0] hold_q,
  output logic              req_tgl
);
  import stl_pkg::*;

  function automatic logic [WORD_W-1:0] left_align(input logic [WORD_W-1:0] raw,
                                                   input int nbytes);
    return raw << (BYTE_W * (MAX_BYTES - nbytes));
  endfunction

  logic [WORD_W-1:0] sh_q, nxt_sh, stage_q, aligned, hold_src;
  logic [CNT_W-1:0]  cnt_q, nxt_cnt;
  logic [LEN_W-1:0]  len_q, nxt_len;
  logic              act_q, stage_v, req_q, ack_s1, ack_s2;
  logic              shifting, word_done, busy, hold_load;

  always_comb begin
    nxt_sh    = ssync ? {{(WORD_W-1){1'b0}}, sdata} : {sh_q[WORD_W-2:0], sdata};
    nxt_len   = ssync ? LEN_W'(clamp_len(int'(cfg_bytes), MAX_BYTES)) : len_q;
    nxt_cnt   = ssync ? CNT_W'(1) : cnt_q + 1'b1;
    shifting  = ssync | act_q;
    word_done = shifting && (int'(nxt_cnt) == int'(nxt_len) * BYTE_W);
    aligned   = left_align(nxt_sh, int'(nxt_len));
    busy      = req_q ^ ack_s2;
    hold_load = (word_done | stage_v) & ~busy;
    hold_src  = word_done ? aligned : stage_q;
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; cnt_q <= '0; len_q <= LEN_W'(1); act_q <= 1'b0;
      stage_q <= '0; stage_v <= 1'b0; hold_q <= '0; req_q <= 1'b0;
      ack_s1 <= 1'b0; ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= ack_tgl;
      ack_s2 <= ack_s1;
      if (shifting) begin
        sh_q  <= nxt_sh;
        cnt_q <= nxt_cnt;
        len_q <= nxt_len;
        act_q <= ~word_done;
      end
      if (word_done && busy) begin
        stage_q <= aligned;
        stage_v <= 1'b1;
      end else if (hold_load) begin
        stage_v <= 1'b0;
      end
      if (hold_load) begin
        hold_q <= hold_src;
        req_q  <= ~req_q;
      end
    end
  end

  assign req_tgl = req_q;

  // R3
  cnt_range_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    act_q |-> (int'(cnt_q) < int'(len_q) * BYTE_W));
  // R6
  hold_stable_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    busy |=> $stable(hold_q));
  // R8
  busy_after_load_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    hold_load |=> busy);
endmodule

// File: rtl/stl_capture.sv
`timescale 1ns/1ps
module stl_capture #(
  parameter int WORD_W = 40,
  parameter int OUT_W  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_tgl,
  input  logic [WORD_W-1:0] hold_i,
  input  logic              term_en,
  output logic [OUT_W-1:0]  tune_word,
  output logic              tune_upd,
  output logic              ack_tgl
);
  logic              req_s1, req_s2, req_s3, upd_q, cap_evt;
  logic [WORD_W-1:0] slave_q;

  assign cap_evt = req_s2 ^ req_s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s1 <= 1'b0; req_s2 <= 1'b0; req_s3 <= 1'b0;
      upd_q <= 1'b0; slave_q <= '0;
    end else begin
      req_s1 <= req_tgl;
      req_s2 <= req_s1;
      req_s3 <= req_s2;
      upd_q  <= cap_evt;
      if (cap_evt) slave_q <= hold_i;
    end
  end

  assign ack_tgl   = req_s3;
  assign tune_upd  = upd_q;
  assign tune_word = term_en ? {slave_q, {(OUT_W-WORD_W){1'b0}}} : '0;

  // R10
  slave_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(slave_q));
endmodule

// File: rtl/serial_tune_loader.sv
`timescale 1ns/1ps
module serial_tune_loader #(
  parameter int MAX_BYTES = 5,
  parameter int BYTE_W    = 8,
  parameter int OUT_W     = 48,
  localparam int WORD_W   = MAX_BYTES * BYTE_W,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             sdata,
  input  logic             ssync,
  input  logic [LEN_W-1:0] cfg_bytes,
  input  logic             term_en,
  output logic [OUT_W-1:0] tune_word,
  output logic             tune_upd
);
  logic [WORD_W-1:0] hold_w;
  logic              req_w, ack_w;

  stl_shifter #(.MAX_BYTES(MAX_BYTES), .BYTE_W(BYTE_W)) u_shift (
    .sclk(sclk), .rst_n(rst_n), .sdata(sdata), .ssync(ssync),
    .cfg_bytes(cfg_bytes), .ack_tgl(ack_w), .hold_q(hold_w), .req_tgl(req_w));

  stl_capture #(.WORD_W(WORD_W), .OUT_W(OUT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .req_tgl(req_w), .hold_i(hold_w),
    .term_en(term_en), .tune_word(tune_word), .tune_upd(tune_upd), .ack_tgl(ack_w));
endmodule

// File: tb/serial_tune_loader_tb.sv
`timescale 1ns/1ps
module serial_tune_loader_tb;
  localparam real CLK_PER = 10.0;

  logic clk = 1'b0, sclk = 1'b0, rst_n = 1'b0;
  logic sdata = 1'b0, ssync = 1'b0, term_en = 1'b1;
  logic [2:0] cfg_bytes = 3'd1;
  logic [47:0] tune_word;
  logic tune_upd;
  real shalf = 7.0;
  int checks = 0, errors = 0;
  logic [47:0] seen [0:7];
  int nseen;

  serial_tune_loader u_dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata),
    .ssync(ssync), .cfg_bytes(cfg_bytes), .term_en(term_en),
    .tune_word(tune_word), .tune_upd(tune_upd));

  always #(CLK_PER/2.0) clk = ~clk;
  always #(shalf) sclk = ~sclk;

  function automatic int nbytes_of(input logic [2:0] c);
    return (c == 3'd0) ? 1 : ((c > 3'd5) ? 5 : int'(c));
  endfunction

  function automatic logic [47:0] expect_word(input logic [39:0] d, input int nbits);
    logic [47:0] r = '0;
    for (int i = 0; i < nbits; i++) r[47-i] = d[nbits-1-i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [47:0] act,
                     input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] c, input logic [39:0] d, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge sclk);
      ssync = (i == 0);
      cfg_bytes = c;
      sdata = d[nbits-1-i];
    end
    @(negedge sclk);
    ssync = 1'b0;
    sdata = 1'b0;
  endtask

  // Wait for one update and compare; returns when found or after timeout.
  task automatic wait_upd(input logic [47:0] exp, input string req);
    bit got = 0;
    for (int k = 0; k < 600 && !got; k++) begin
      @(negedge clk);
      if (tune_upd) begin
        got = 1;
        chk(tune_word == exp, req, tune_word, exp);
      end
    end
    if (!got) chk(1'b0, {req, " no update (R5)"}, tune_word, exp);
  endtask

  task automatic collect(input int ncyc);
    nseen = 0;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      if (tune_upd && nseen < 8) begin
        seen[nseen] = tune_word;
        nseen++;
      end
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PER * 150000.0);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 48'h0, 48'h1);
    finish_run();
  end

  initial begin
    logic [39:0] d;
    logic [2:0] c;
    int nb;
    void'($urandom(32'd1234));
    #(CLK_PER * 3.3);
    // R1 reset state
    chk(tune_word == 48'h0, "R1 word", tune_word, 48'h0);
    chk(tune_upd == 1'b0, "R1 upd", {47'h0, tune_upd}, 48'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R4: each length 1..5
    for (int n = 1; n <= 5; n++) begin
      d = 40'hA5_3C_96_E1_7B;
      fork
        send(3'(n), d, 8*n);
        wait_upd(expect_word(d, 8*n), $sformatf("R4 R2 len=%0d", n));
      join
    end

    // R3 clamp: code 0 acts as 1 byte, code 7 as 5 bytes
    d = 40'h00_00_00_00_C3;
    fork send(3'd0, d, 8); wait_upd(expect_word(d, 8), "R3 code0"); join
    d = 40'h12_34_56_78_9A;
    fork send(3'd7, d, 40); wait_upd(expect_word(d, 40), "R3 code7"); join

    // R9 gating
    @(negedge clk); term_en = 1'b0; #1;
    chk(tune_word == 48'h0, "R9 gated", tune_word, 48'h0);
    @(negedge clk); term_en = 1'b1; #1;
    chk(tune_word == expect_word(d, 40), "R9 restored", tune_word, expect_word(d, 40));

    // R7 partial frame abandoned by new sync
    d = 40'h00_00_FF_FF_FF;
    fork
      begin
        send(3'd3, d, 12);
        send(3'd2, 40'h00_00_00_5A_A5, 16);
      end
      collect(150);
    join
    chk(nseen == 1, "R7 one update", 48'(nseen), 48'd1);
    chk(seen[0] == expect_word(40'h5AA5, 16), "R7 new word", seen[0],
        expect_word(40'h5AA5, 16));

    // R8 burst during open hand-off at fast serial clock
    shalf = 1.0;
    fork
      begin
        send(3'd1, 40'h11, 8);
        send(3'd1, 40'h22, 8);
        send(3'd1, 40'h33, 8);
      end
      collect(60);
    join
    chk(nseen >= 1, "R8 any update", 48'(nseen), 48'd1);
    chk(seen[0] == expect_word(40'h11, 8), "R8 first", seen[0], expect_word(40'h11, 8));
    chk(nseen >= 1 && seen[nseen-1] == expect_word(40'h33, 8), "R8 last",
        seen[(nseen > 0) ? nseen-1 : 0], expect_word(40'h33, 8));
    for (int k = 1; k < nseen; k++)
      chk(seen[k] == expect_word(40'h22, 8) || seen[k] == expect_word(40'h33, 8),
          "R8 member", seen[k], expect_word(40'h33, 8));

    // Random words, lengths and serial clock periods (R2 R3 R4 R5)
    for (int t = 0; t < 24; t++) begin
      case ($urandom_range(3)) 0: shalf = 2.0; 1: shalf = 4.5; 2: shalf = 7.0; default: shalf = 11.0; endcase
      c = 3'($urandom_range(7));
      nb = nbytes_of(c);
      d = {8'($urandom), 32'($urandom)};
      repeat (2) @(negedge sclk);
      fork
        send(c, d, 8*nb);
        wait_upd(expect_word(d, 8*nb), $sformatf("R5 R4 rand t=%0d", t));
      join
    end
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule